// File: doc/BRIEF.md
# Overlapping Windowed Integer Register File

This block is a 32-bit integer register file with 32 architectural register numbers. Those numbers map onto a larger physical store of 136 entries. The store holds eight globals and 128 windowed entries, and the windowed entries form eight circular windows. A window-pointer input selects which window the architectural numbers 8 to 31 refer to:

- Numbers 0 to 7 are globals and reach the same entries in every window.
- Numbers 8 to 15 are the outs of the selected window.
- Numbers 16 to 23 are its locals.
- Numbers 24 to 31 are its ins.

Moving the pointer by one shifts the windowed mapping by sixteen physical entries. As a result, the outs of window w are the same storage as the ins of window w-1. The ring is closed, so the outs of window 0 are the ins of window 7.

The block has two combinational read ports and one clocked write port. Register 0 always reads as zero, and writes to it are dropped. Only the low three bits of the five-bit window pointer take part in the mapping. A read of an entry in the same cycle that it is written returns the stored value, not the value being written. Detecting window overflow, sequencing traps and spilling windows are left to the surrounding logic.

Top module: `winrf_top`

## Requirements
- R1: A synchronous active-high reset clears every physical entry, so that after reset every register number reads 0 in every window.
- R2: Architectural register 0 reads 0 on both ports, and a write that targets register 0 changes no register.
- R3: Registers 1 to 7 reach the same storage whatever the window pointer is: a value written under one window reads back under every window.
- R4: A write with `wr_en` high updates the addressed register at the rising clock edge. From then on, a read of that register number under the same window returns the written value.
- R5: A read of the register being written in the same cycle returns the old value; there is no bypass from write data to read data.
- R6: Register 8+k (outs, k = 0..7) of window w is the same storage as register 24+k (ins) of window (w-1) mod 8. This includes the wrap, where the outs of window 0 are the ins of window 7.
- R7: Registers 16 to 23 (locals) of a window are private: a write to them is not visible through any register number of any other window.
- R8: Only `cwp_i[2:0]` selects the window. Pointer values that differ only in bits 4:3 give identical reads and writes.
- R9: The two read ports are independent, and each returns the stored value of its own register number under the current window, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes and reset act on its rising edge |
| rst | input | 1 | Synchronous active-high reset, clears all storage |
| cwp_i | input | 5 | Current window pointer; the low 3 bits select the window |
| rd_a_idx | input | 5 | Architectural register number for read port A |
| rd_a_data | output | 32 | Read data of port A, combinational |
| rd_b_idx | input | 5 | Architectural register number for read port B |
| rd_b_data | output | 32 | Read data of port B, combinational |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | 32 | Data to write |

## Verification
Read data is combinational, so it is due in the same cycle as the register number and window pointer that select it. The bench drives those inputs on the falling edge and samples a short delay later, well before the next rising edge. A write lands at the first rising edge after it is driven. It therefore becomes visible from that edge on, and a read sampled before that edge must still show the old value. The bench checks both sides of that edge for the same register. The sweeps cover every register number under all 32 pointer values, with expected data computed from an arithmetic model of the window ring.

// File: rtl/winrf_pkg.sv
package winrf_pkg;

    // architectural register number width
    localparam int ARCH_W     = 5;
    // size of each register group (globals, outs, locals, ins)
    localparam int GROUP_N    = 8;
    // physical shift between neighbouring windows
    localparam int WIN_STRIDE = 16;

    typedef logic [ARCH_W-1:0] arch_idx_t;

    typedef enum logic [1:0] {
        GRP_GLOBAL = 2'd0,
        GRP_OUT    = 2'd1,
        GRP_LOCAL  = 2'd2,
        GRP_IN     = 2'd3
    } reg_group_e;

    // classify an architectural number by its high two bits
    function automatic reg_group_e group_of(arch_idx_t idx);
        return reg_group_e'(idx[ARCH_W-1:ARCH_W-2]);
    endfunction

    // write request carried from the port to the storage
    typedef struct packed {
        logic      en;
        arch_idx_t idx;
        logic [31:0] data;
    } wr_req_t;

endpackage

// File: rtl/winrf_xlate.sv
module winrf_xlate
    import winrf_pkg::*;
#(
    parameter int NUM_WIN = 8,
    parameter int CWP_W   = 5,
    parameter int PIDX_W  = 8
) (
    input  arch_idx_t          arch_idx,
    input  logic [CWP_W-1:0]   cwp,
    output logic [PIDX_W-1:0]  phys_idx
);
    localparam int RING_N = NUM_WIN * WIN_STRIDE;
    localparam int FULL_W = CWP_W + 5;

    logic [FULL_W-1:0] base;
    logic [FULL_W-1:0] offset;
    logic [FULL_W-1:0] ring_pos;
    reg_group_e        grp;

    always_comb begin
        grp      = group_of(arch_idx);
        base     = FULL_W'(cwp) * FULL_W'(WIN_STRIDE);
        offset   = FULL_W'(arch_idx) - FULL_W'(GROUP_N);
        ring_pos = (base + offset) % FULL_W'(RING_N);
        if (grp == GRP_GLOBAL) begin
            phys_idx = PIDX_W'(arch_idx);
        end else begin
            phys_idx = PIDX_W'(ring_pos) + PIDX_W'(GROUP_N);
        end
    end
endmodule

// File: rtl/winrf_store.sv
module winrf_store #(
    parameter int DATA_W = 32,
    parameter int PHYS_N = 136,
    parameter int PIDX_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PIDX_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PIDX_W-1:0] raddr_a,
    output logic [DATA_W-1:0] rdata_a,
    input  logic [PIDX_W-1:0] raddr_b,
    output logic [DATA_W-1:0] rdata_b
);
    logic [DATA_W-1:0] cells [PHYS_N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < PHYS_N; k++) begin
                cells[k] <= '0;
            end
        end else if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata_a = cells[raddr_a];
    assign rdata_b = cells[raddr_b];
endmodule

// File: rtl/winrf_top.sv
module winrf_top
    import winrf_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_WIN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [4:0]        cwp_i,
    input  logic [4:0]        rd_a_idx,
    output logic [DATA_W-1:0] rd_a_data,
    input  logic [4:0]        rd_b_idx,
    output logic [DATA_W-1:0] rd_b_data,
    input  logic              wr_en,
    input  logic [4:0]        wr_idx,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int PHYS_N = GROUP_N + NUM_WIN * WIN_STRIDE;
    localparam int PIDX_W = $clog2(PHYS_N);
    localparam int NPORT  = 3;  // read A, read B, write

    arch_idx_t         port_idx  [NPORT];
    logic [PIDX_W-1:0] port_phys [NPORT];
    logic [DATA_W-1:0] raw_a, raw_b;
    logic              wr_live;

    assign port_idx[0] = rd_a_idx;
    assign port_idx[1] = rd_b_idx;
    assign port_idx[2] = wr_idx;

    for (genvar p = 0; p < NPORT; p++) begin : g_xlate
        winrf_xlate #(
            .NUM_WIN (NUM_WIN),
            .CWP_W   (5),
            .PIDX_W  (PIDX_W)
        ) u_xlate (
            .arch_idx (port_idx[p]),
            .cwp      (cwp_i),
            .phys_idx (port_phys[p])
        );
    end

    // register 0 never takes a write
    assign wr_live = wr_en && (wr_idx != '0);

    winrf_store #(
        .DATA_W (DATA_W),
        .PHYS_N (PHYS_N),
        .PIDX_W (PIDX_W)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (wr_live),
        .waddr   (port_phys[2]),
        .wdata   (wr_data),
        .raddr_a (port_phys[0]),
        .rdata_a (raw_a),
        .raddr_b (port_phys[1]),
        .rdata_b (raw_b)
    );

    assign rd_a_data = (rd_a_idx == '0) ? '0 : raw_a;
    assign rd_b_data = (rd_b_idx == '0) ? '0 : raw_b;
endmodule

// File: rtl/winrf_checker.sv
module winrf_checker #(
    parameter int DATA_W  = 32,
    parameter int NUM_WIN = 8
) (
    input logic              clk,
    input logic              rst,
    input logic [4:0]        cwp_i,
    input logic [4:0]        rd_a_idx,
    input logic [DATA_W-1:0] rd_a_data,
    input logic [4:0]        rd_b_idx,
    input logic [DATA_W-1:0] rd_b_data,
    input logic              wr_en,
    input logic [4:0]        wr_idx,
    input logic [DATA_W-1:0] wr_data
);
    localparam int WB = $clog2(NUM_WIN);

    logic [WB-1:0] win_now;
    assign win_now = WB'(cwp_i % 5'(NUM_WIN));

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd_a_data == '0 && rd_b_data == '0));

    // R2
    zero_reg_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == 5'd0) |-> (rd_a_data == '0));

    // R3
    global_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) && rd_a_idx < 5'd8 &&
         rd_a_idx == $past(rd_a_idx)) |-> $stable(rd_a_data));

    // R4
    write_land_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr_en) && $past(wr_idx) != 5'd0 &&
         rd_b_idx == $past(wr_idx) && win_now == $past(win_now))
        |-> (rd_b_data == $past(wr_data)));

    // R6
    overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(wr_en) &&
         $past(rd_a_idx) >= 5'd8 && $past(rd_a_idx) <= 5'd15 &&
         rd_a_idx == $past(rd_a_idx) + 5'd16 &&
         win_now == $past(win_now) - WB'(1))
        |-> (rd_a_data == $past(rd_a_data)));

    // R9
    port_agree_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_a_idx == rd_b_idx) |-> (rd_a_data == rd_b_data));
endmodule

bind winrf_top winrf_checker #(
    .DATA_W  (DATA_W),
    .NUM_WIN (NUM_WIN)
) u_winrf_checker (
    .clk       (clk),
    .rst       (rst),
    .cwp_i     (cwp_i),
    .rd_a_idx  (rd_a_idx),
    .rd_a_data (rd_a_data),
    .rd_b_idx  (rd_b_idx),
    .rd_b_data (rd_b_data),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data)
);

// File: tb/test_winrf_top.sv
`timescale 1ns/1ps
module test_winrf_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  cwp_i = '0;
    logic [4:0]  rd_a_idx = '0;
    logic [31:0] rd_a_data;
    logic [4:0]  rd_b_idx = '0;
    logic [31:0] rd_b_data;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] model [136];

    always #5 clk = ~clk;

    winrf_top i_winrf_top (
        .clk       (clk),
        .rst       (rst),
        .cwp_i     (cwp_i),
        .rd_a_idx  (rd_a_idx),
        .rd_a_data (rd_a_data),
        .rd_b_idx  (rd_b_idx),
        .rd_b_data (rd_b_data),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data)
    );

    // physical slot from the window ring arithmetic of R3/R6/R8
    function automatic int slot(int w, int i);
        if (i < 8) return i;
        return 8 + (((w % 8) * 16 + i - 8) % 128);
    endfunction

    function automatic logic [31:0] expect_rd(int w, int i);
        if (i == 0) return 32'h0;
        return model[slot(w, i)];
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_read(int w, int a, int b);
        @(negedge clk);
        cwp_i    = 5'(w);
        rd_a_idx = 5'(a);
        rd_b_idx = 5'(b);
        #2;
    endtask

    task automatic do_write(int w, int i, logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        cwp_i   = 5'(w);
        wr_idx  = 5'(i);
        wr_data = d;
        if (i != 0) model[slot(w, i)] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 136; k++) model[k] = '0;
    endtask

    function automatic string tag_of(int w, int i);
        if (w >= 8) return "R8";
        if (i == 0) return "R2";
        if (i < 8) return "R3";
        if (i >= 16 && i < 24) return "R7";
        return "R6";
    endfunction

    initial begin
        logic [31:0] old_v;
        for (int k = 0; k < 136; k++) model[k] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: everything reads zero after reset
        for (int w = 0; w < 8; w++) begin
            for (int i = 0; i < 32; i++) begin
                set_read(w, i, 31 - i);
                check("R1 port A", rd_a_data, 32'h0);
                check("R1 port B", rd_b_data, 32'h0);
            end
        end

        // fill every register number in every window, r0 included
        for (int w = 0; w < 8; w++) begin
            for (int i = 0; i < 32; i++) begin
                do_write(w, i, 32'hA000_0000 | 32'(w << 8) | 32'(i) | 32'h0010_0000);
            end
        end

        // full sweep over all 32 pointer values
        for (int w = 0; w < 32; w++) begin
            for (int i = 0; i < 32; i++) begin
                set_read(w, i, (i + 13) % 32);
                check(tag_of(w, i), rd_a_data, expect_rd(w, i));
                check("R9 port B", rd_b_data, expect_rd(w, (i + 13) % 32));
            end
        end

        // R2: write to r0 dropped, still reads zero
        do_write(3, 0, 32'hFFFF_FFFF);
        set_read(3, 0, 0);
        check("R2 r0 port A", rd_a_data, 32'h0);
        check("R2 r0 port B", rd_b_data, 32'h0);

        // R3: global written under window 6 seen under window 1
        do_write(6, 5, 32'h0B0B_0005);
        set_read(1, 5, 5);
        check("R3 global across windows", rd_a_data, 32'h0B0B_0005);

        // R6: wrap, outs of window 0 are ins of window 7
        do_write(0, 9, 32'h1234_0009);
        set_read(7, 25, 9);
        check("R6 wrap out0->in7", rd_a_data, 32'h1234_0009);
        do_write(4, 14, 32'h4444_000E);
        set_read(3, 30, 30);
        check("R6 out4->in3", rd_a_data, 32'h4444_000E);

        // R7: local of window 3 invisible elsewhere
        do_write(3, 20, 32'h5EED_0014);
        for (int w = 0; w < 8; w++) begin
            if (w != 3) begin
                for (int i = 8; i < 32; i++) begin
                    set_read(w, i, i);
                    check("R7 local private", rd_a_data, expect_rd(w, i));
                end
            end
        end
        set_read(3, 20, 20);
        check("R7 local own window", rd_a_data, 32'h5EED_0014);

        // R8: upper pointer bits ignored on write
        do_write(2 + 24, 18, 32'h0808_0012);
        set_read(2, 18, 18);
        check("R8 write with high bits", rd_a_data, 32'h0808_0012);

        // R5 and R4: same-cycle read sees old value, new value after edge
        @(negedge clk);
        cwp_i    = 5'd2;
        rd_a_idx = 5'd17;
        rd_b_idx = 5'd17;
        wr_en    = 1'b1;
        wr_idx   = 5'd17;
        wr_data  = 32'hC0DE_0011;
        #2;
        old_v = model[slot(2, 17)];
        check("R5 no bypass port A", rd_a_data, old_v);
        check("R5 no bypass port B", rd_b_data, old_v);
        model[slot(2, 17)] = 32'hC0DE_0011;
        @(posedge clk);
        #2;
        check("R4 write landed", rd_a_data, 32'hC0DE_0011);
        @(negedge clk);
        wr_en = 1'b0;

        // R1: reset after traffic clears all
        pulse_reset();
        for (int w = 0; w < 8; w++) begin
            for (int i = 0; i < 32; i++) begin
                set_read(w, i, i);
                check("R1 after reset", rd_a_data, 32'h0);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog all requirements actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule